// File: doc/BRIEF.md
# Collision Detector with Test Echo

This block drives the collision indication of a 10/100 media-independent interface from the activity it sees on the line. In half duplex the indication is raised while a local transmission (`txEn`) and a receive in progress (`rxActive`) overlap. The indication is lowered for as long as the overlap has ended. Selecting full duplex suppresses the indication completely, because simultaneous traffic is normal in that mode.

A test mode lets a link partner or bring-up software check the collision path without a second station. While `colTest` is set, the indication copies `txEn` through a short delay line that advances once per bit time. That gives fixed assert and deassert latencies that fall well inside the allowed limits.

The block runs on a single internal clock. A one-cycle strobe `bitTick` marks each bit time. All latencies in test mode are counted in those strobes.

Top module: `collision_detector`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `col` is 0. The bit-time delay line also starts cleared.
- R2: In half duplex (`fullDuplex`=0) with `colTest`=0, `col` equals `txEn & rxActive` as sampled at the previous rising clock edge, so it has one clock of latency.
- R3: In normal half-duplex operation, `col` stays 1 for every cycle the overlap persists. It falls one clock after either activity drops.
- R4: When `fullDuplex`=1 at a clock edge, `col` is 0 after that edge. This holds regardless of `colTest`, `txEn` and `rxActive`, so full duplex outranks test mode.
- R5: With `colTest`=1 and half duplex, `col` is `txEn` delayed by two bit times. `txEn` is sampled at each edge where `bitTick`=1, and the value sampled two ticks earlier is presented one clock after the latest tick. `rxActive` has no effect in this mode.
- R6: In test mode, `col` rises no later than 512 bit ticks after `txEn` rises. (The design takes 2.)
- R7: In test mode, `col` falls no later than 4 bit ticks after `txEn` falls. (The design takes 2.)
- R8: Test mode outranks normal detection: with `colTest`=1, a fresh overlap of `txEn` and `rxActive` does not raise `col` on the next clock.
- R9: The test delay line advances only on edges with `bitTick`=1. A `txEn` pulse that starts and ends between two ticks never reaches `col`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitTick | input | 1 | One-cycle strobe, once per bit time |
| txEn | input | 1 | Local transmit enable |
| rxActive | input | 1 | Receive activity present |
| fullDuplex | input | 1 | 1 selects full duplex (collision suppressed) |
| colTest | input | 1 | 1 selects collision test echo of txEn |
| col | output | 1 | Collision indication |

## Verification
In normal and full-duplex operation, `col` is due exactly one clock after the inputs that cause it. In test mode it is due one clock after the second bit tick that follows a change of `txEn`. The bench therefore drives inputs just after the falling edge. A behavioural model updates on each rising edge from a two-entry queue of tick-sampled `txEn` values, and `col` is compared at every falling edge. Test-mode latencies are additionally measured as a count of ticks between a `txEn` edge and the matching `col` edge, then compared against both the exact value of 2 and the 512- and 4-tick limits.

// File: rtl/collision_pkg.sv
package collision_pkg;

  // Strobes passed from the control module to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;   // advance the test delay line this cycle
    logic useTest;   // present the delayed transmit copy instead of overlap
    logic suppress;  // force the output low (full duplex)
  } colStrobes_t;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_QUIET  = 2'd2
  } colMode_t;

endpackage

// File: rtl/collision_ctrl.sv
module collision_ctrl
  import collision_pkg::*;
(
  input  logic        bitTick,
  input  logic        fullDuplex,
  input  logic        colTest,
  output colStrobes_t strobes,
  output colMode_t    mode
);

  // Full duplex outranks test mode, which outranks normal detection.
  always_comb begin
    if (fullDuplex)   mode = MODE_QUIET;
    else if (colTest) mode = MODE_TEST;
    else              mode = MODE_NORMAL;
  end

  always_comb begin
    strobes.shiftEn  = bitTick;
    strobes.useTest  = (mode == MODE_TEST);
    strobes.suppress = (mode == MODE_QUIET);
  end

endmodule

// File: rtl/collision_datapath.sv
module collision_datapath
  import collision_pkg::*;
#(
  parameter int TEST_DELAY = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        txEn,
  input  logic        rxActive,
  input  colStrobes_t strobes,
  output logic        col
);

  localparam int LAST = TEST_DELAY - 1;

  logic [TEST_DELAY-1:0] txDelay;
  logic                  overlap;
  logic                  colNext;

  // Delay line of txEn samples, one stage per bit tick.
  generate
    for (genvar i = 0; i < TEST_DELAY; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                txDelay[i] <= 1'b0;
          else if (strobes.shiftEn) txDelay[i] <= txEn;
        end
      end else begin : g_tail
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                txDelay[i] <= 1'b0;
          else if (strobes.shiftEn) txDelay[i] <= txDelay[i-1];
        end
      end
    end
  endgenerate

  assign overlap = txEn & rxActive;

  always_comb begin
    if (strobes.suppress)     colNext = 1'b0;
    else if (strobes.useTest) colNext = txDelay[LAST];
    else                      colNext = overlap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) col <= 1'b0;
    else       col <= colNext;
  end

endmodule

// File: rtl/collision_detector.sv
module collision_detector
  import collision_pkg::*;
#(
  parameter int TEST_DELAY = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic bitTick,
  input  logic txEn,
  input  logic rxActive,
  input  logic fullDuplex,
  input  logic colTest,
  output logic col
);

  colStrobes_t strobes;
  colMode_t    mode;

  collision_ctrl u_ctrl (
    .bitTick    (bitTick),
    .fullDuplex (fullDuplex),
    .colTest    (colTest),
    .strobes    (strobes),
    .mode       (mode)
  );

  collision_datapath #(.TEST_DELAY(TEST_DELAY)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .txEn     (txEn),
    .rxActive (rxActive),
    .strobes  (strobes),
    .col      (col)
  );

endmodule

// File: rtl/collision_detector_checker.sv
module collision_detector_checker #(
  parameter int ASSERT_BOUND   = 512,
  parameter int DEASSERT_BOUND = 4
) (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic txEn,
  input logic rxActive,
  input logic fullDuplex,
  input logic colTest,
  input logic col
);

  localparam int CW = $clog2(ASSERT_BOUND + 2) + 1;

  logic [CW-1:0] riseTicks;
  logic [CW-1:0] fallTicks;

  // Ticks elapsed while test mode holds txEn high (R6) or low (R7).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseTicks <= '0;
      fallTicks <= '0;
    end else begin
      if (!(colTest && !fullDuplex && txEn)) riseTicks <= '0;
      else if (bitTick && riseTicks < CW'(ASSERT_BOUND + 1)) riseTicks <= riseTicks + 1'b1;
      if (!(colTest && !fullDuplex && !txEn)) fallTicks <= '0;
      else if (bitTick && fallTicks < CW'(ASSERT_BOUND + 1)) fallTicks <= fallTicks + 1'b1;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) !rstN |=> !col);

  assert_overlap_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && !colTest && txEn && rxActive) |=> col);

  assert_no_overlap_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!fullDuplex && !colTest && !(txEn && rxActive)) |=> !col);

  assert_full_duplex_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    fullDuplex |=> !col);

  assert_test_assert_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (riseTicks > CW'(2) && riseTicks <= CW'(ASSERT_BOUND)) |-> col);

  assert_test_deassert_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fallTicks > CW'(2) && fallTicks <= CW'(DEASSERT_BOUND + 1)) |-> !col);

  assert_test_hold_between_ticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    (colTest && !fullDuplex && $past(colTest && !fullDuplex) && !$past(bitTick)) |=> $stable(col));

endmodule

bind collision_detector collision_detector_checker #(
  .ASSERT_BOUND   (512),
  .DEASSERT_BOUND (4)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitTick    (bitTick),
  .txEn       (txEn),
  .rxActive   (rxActive),
  .fullDuplex (fullDuplex),
  .colTest    (colTest),
  .col        (col)
);

// File: tb/collision_detector_test.sv
`timescale 1ns/1ps
module collision_detector_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitTick = 1'b0;
  logic txEn = 1'b0;
  logic rxActive = 1'b0;
  logic fullDuplex = 1'b0;
  logic colTest = 1'b0;
  logic col;

  int checks = 0;
  int errors = 0;
  int tickTotal = 0;
  int tickPhase = 0;
  bit compareOn = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  collision_detector uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .txEn(txEn),
    .rxActive(rxActive), .fullDuplex(fullDuplex), .colTest(colTest), .col(col)
  );

  // Bit tick: one cycle in four, changed at the falling edge.
  always @(negedge clk) begin
    tickPhase <= (tickPhase + 1) % 4;
    bitTick   <= (tickPhase == 2);
  end

  always @(posedge clk) if (bitTick) tickTotal <= tickTotal + 1;

  // Behavioural reference: queue of tick-sampled txEn, oldest first.
  bit    hist[$];
  bit    expCol = 1'b0;
  string expTag = "R1";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = {1'b0, 1'b0};
      expCol <= 1'b0;
      expTag <= "R1";
    end else begin
      if (fullDuplex) begin
        expCol <= 1'b0; expTag <= "R4";
      end else if (colTest) begin
        expCol <= hist[0]; expTag <= "R5";
      end else begin
        expCol <= txEn && rxActive; expTag <= "R2";
      end
      if (bitTick) begin
        hist.push_back(txEn);
        void'(hist.pop_front());
      end
    end
  end

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compareOn) check(col, expCol, expTag, "model compare");

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #0.5;
    end
  endtask

  task automatic randomRun(input int n, input bit fd, input bit ct);
    for (int i = 0; i < n; i++) begin
      step(1);
      fullDuplex = fd; colTest = ct;
      if (ct) begin
        if (($urandom % 12) == 0) txEn = ~txEn;
      end else txEn = $urandom % 2;
      rxActive = $urandom % 2;
    end
  endtask

  task automatic measureLatency();
    int t0;
    int lat;
    fullDuplex = 0; colTest = 1; txEn = 0; rxActive = 1;
    step(20);
    txEn = 1; t0 = tickTotal; lat = -1;
    for (int i = 0; i < 3000; i++) begin
      step(1);
      if (col) begin lat = tickTotal - t0; break; end
    end
    check(lat == 2, 1'b1, "R5", "rise latency is 2 ticks");
    check(lat >= 0 && lat <= 512, 1'b1, "R6", "rise within 512 ticks");
    step(10);
    txEn = 0; t0 = tickTotal; lat = -1;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (!col) begin lat = tickTotal - t0; break; end
    end
    check(lat == 2, 1'b1, "R5", "fall latency is 2 ticks");
    check(lat >= 0 && lat <= 4, 1'b1, "R7", "fall within 4 ticks");
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    check(col, 1'b0, "R1", "col low in reset");
    rstN = 1;
    step(1);
    check(col, 1'b0, "R1", "col low after release");
    compareOn = 1;

    // R2 / R3: explicit overlap and release.
    txEn = 1; rxActive = 1; step(1);
    check(col, 1'b1, "R2", "overlap raises col");
    step(5);
    check(col, 1'b1, "R3", "col held during overlap");
    rxActive = 0; step(1);
    check(col, 1'b0, "R3", "col drops after overlap");
    txEn = 0;
    randomRun(400, 0, 0);

    // R4: full duplex suppression, both modes.
    txEn = 1; rxActive = 1; fullDuplex = 1; step(1);
    check(col, 1'b0, "R4", "full duplex suppresses overlap");
    randomRun(300, 1, 0);
    randomRun(300, 1, 1);

    // R8: test mode outranks a fresh overlap.
    fullDuplex = 0; colTest = 1; txEn = 0; rxActive = 0; step(20);
    txEn = 1; rxActive = 1; step(1);
    check(col, 1'b0, "R8", "overlap ignored in test mode");
    txEn = 0; step(20);

    // R9: pulse between ticks never reaches col.
    while (bitTick) step(1);
    txEn = 1; step(1); txEn = 0;
    for (int i = 0; i < 16; i++) begin
      step(1);
      check(col, 1'b0, "R9", "inter-tick pulse filtered");
    end

    measureLatency();
    randomRun(600, 0, 1);

    // Mode churn.
    for (int i = 0; i < 800; i++) begin
      step(1);
      fullDuplex = (($urandom % 8) == 0);
      if (($urandom % 30) == 0) colTest = ~colTest;
      txEn = ($urandom % 3) != 0;
      rxActive = $urandom % 2;
    end
    step(2);
    compareOn = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule